// File: doc/BRIEF.md
# Supply Recharge Activity Monitor

This block watches a periodic supply-recharge controller while the device sits in standby. The inputs are a strobe marking the start of each recharge, a comparator bit that tells whether the supply was still above its OK threshold at that start, a 32 kHz low-frequency tick, and a write strobe from the register bus. From these the block keeps a short history of threshold samples and the longest healthy gap between two recharges. A healthy gap is one where the supply was still above threshold when the later recharge began. Software reads both through one status word and clears the maximum by writing that word.

A free-running interval counter counts low-frequency ticks since the last recharge start. At each start the counter value is compared against the stored maximum. The counter then restarts from zero. The block also holds a 2-bit recharge-mode field that software can load. The block only observes and reports. It drives no part of the recharge itself.

Top module: `rchg_monitor`

## Requirements
- R1: In a cycle with `rchg_start_i` high, `status_o[19:16]` takes the value {previous `status_o[18:16]`, `above_ok_i`} on the next cycle. A sample bit of 1 means the supply was above threshold when that recharge began, and 0 means it was below.
- R2: In a cycle with `rchg_start_i` low, `status_o[19:16]` keeps its value.
- R3: The interval count is the number of cycles with `lf_tick_i` high since the last recharge start, or since reset. It restarts at zero on a start, and a tick in the same cycle as a start is not counted.
- R4: At a start with `above_ok_i` = 1 and an interval count greater than `status_o[15:0]`, `status_o[15:0]` takes that count on the next cycle. Otherwise it keeps its value: when `above_ok_i` = 0, when the count is not greater, or when there is no start.
- R5: A cycle with `stat_wr_i` high clears `status_o[15:0]` to zero on the next cycle. This takes priority over an R4 update in the same cycle.
- R6: The interval count saturates at 65535 rather than wrapping.
- R7: `mode_o` resets to 3 and loads `mode_wdata_i` in a cycle with `mode_wr_i` high. Otherwise it holds. The encodings are 0 = recharge off, 1 = fixed timer, 2 = adaptive timer, 3 = external comparator.
- R8: After reset `status_o` is zero. `status_o[31:20]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rchg_start_i | input | 1 | One-cycle strobe at each recharge start |
| above_ok_i | input | 1 | Supply above OK threshold, sampled at a start |
| lf_tick_i | input | 1 | One-cycle pulse per 32 kHz period |
| stat_wr_i | input | 1 | Status-word write strobe, clears the maximum |
| mode_wr_i | input | 1 | Mode-field write strobe |
| mode_wdata_i | input | 2 | Mode value to load |
| mode_o | output | 2 | Current recharge mode |
| status_o | output | 32 | {12'b0, sample history[3:0], maximum interval[15:0]} |

## Verification
A wrong interval count stays hidden until the next start that qualifies: only then does the count reach `status_o[15:0]`. The bench therefore checks the maximum one cycle after every start, and a miscount shows up as a maximum that is too large or too small. A history fault shows in `status_o[19:16]` one cycle after the faulty start, and then moves one position left with each further start. A clear that loses to an update appears as a nonzero maximum one cycle after the write. A counter that wraps is caught by the saturation case.

// File: rtl/rchg_pkg.sv
package rchg_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_ADAPT  = 2'd2,
    MODE_EXTCMP = 2'd3
  } rchg_mode_e;
endpackage

// File: rtl/rchg_interval_ctr.sv
module rchg_interval_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != CNT_TOP)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_TOP && !start_i) |=> (cnt_q == CNT_TOP)); // R6
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/rchg_sample_hist.sv
module rchg_sample_hist #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sample_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (start_i) begin
      hist_q <= {hist_q[HIST_W-2:0], sample_i};
    end
  end

  assign hist_o = hist_q;

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]))); // R1
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(hist_q)); // R2
endmodule

// File: rtl/rchg_max_track.sv
module rchg_max_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             healthy_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] max_o
);
  logic [CNT_W-1:0] max_q;
  logic             take;

  assign take = start_i && healthy_i && (cnt_i > max_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q <= '0;
    end else if (clr_i) begin
      max_q <= '0;
    end else if (take) begin
      max_q <= cnt_i;
    end
  end

  assign max_o = max_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (max_q == '0)); // R5
  AST_MAX_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !start_i) |=> $stable(max_q)); // R4
  AST_MAX_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (max_q >= $past(max_q))); // R4
  AST_MAX_UNHEALTHY: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !healthy_i) |=> $stable(max_q)); // R4
endmodule

// File: rtl/rchg_monitor.sv
module rchg_monitor #(
  parameter int CNT_W  = 16,
  parameter int HIST_W = 4,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rchg_start_i,
  input  logic              above_ok_i,
  input  logic              lf_tick_i,
  input  logic              stat_wr_i,
  input  logic              mode_wr_i,
  input  logic [1:0]        mode_wdata_i,
  output logic [1:0]        mode_o,
  output logic [STAT_W-1:0] status_o
);
  import rchg_pkg::*;

  localparam int PAD_W = STAT_W - HIST_W - CNT_W;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  max_val;
  logic [HIST_W-1:0] hist;
  rchg_mode_e        mode_q;

  rchg_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .start_i (rchg_start_i),
    .tick_i  (lf_tick_i),
    .cnt_o   (cnt)
  );

  rchg_sample_hist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .start_i  (rchg_start_i),
    .sample_i (above_ok_i),
    .hist_o   (hist)
  );

  rchg_max_track #(.CNT_W(CNT_W)) u_max (
    .clk       (clk),
    .rst       (rst),
    .start_i   (rchg_start_i),
    .healthy_i (above_ok_i),
    .clr_i     (stat_wr_i),
    .cnt_i     (cnt),
    .max_o     (max_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_EXTCMP;
    end else if (mode_wr_i) begin
      mode_q <= rchg_mode_e'(mode_wdata_i);
    end
  end

  assign mode_o   = mode_q;
  assign status_o = {{PAD_W{1'b0}}, hist, max_val};

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mode_wr_i |=> $stable(mode_o)); // R7
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    mode_wr_i |=> (mode_o == $past(mode_wdata_i))); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_o[STAT_W-1:HIST_W+CNT_W] == '0); // R8
endmodule

// File: tb/rchg_monitor_bench.sv
`timescale 1ns/1ps
module rchg_monitor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rchg_start_i = 1'b0;
  logic        above_ok_i = 1'b0;
  logic        lf_tick_i = 1'b0;
  logic        stat_wr_i = 1'b0;
  logic        mode_wr_i = 1'b0;
  logic [1:0]  mode_wdata_i = 2'd0;
  logic [1:0]  mode_o;
  logic [31:0] status_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] m_cnt;
  logic [15:0] m_max;
  logic [3:0]  m_hist;
  logic [1:0]  m_mode;

  always #5 clk = ~clk;

  rchg_monitor u_rchg_monitor (
    .clk(clk), .rst(rst), .rchg_start_i(rchg_start_i), .above_ok_i(above_ok_i),
    .lf_tick_i(lf_tick_i), .stat_wr_i(stat_wr_i), .mode_wr_i(mode_wr_i),
    .mode_wdata_i(mode_wdata_i), .mode_o(mode_o), .status_o(status_o)
  );

  function automatic logic [15:0] f_next_max(logic [15:0] mx, logic [15:0] c,
                                             logic s, logic a, logic w);
    if (w) return 16'd0;
    if (s && a && (c > mx)) return c;
    return mx;
  endfunction

  function automatic logic [15:0] f_next_cnt(logic [15:0] c, logic s, logic t);
    if (s) return 16'd0;
    if (t && c != 16'hFFFF) return c + 16'd1;
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic s, logic a, logic t, logic w,
                      logic mw, logic [1:0] md, bit do_chk);
    rchg_start_i = s; above_ok_i = a; lf_tick_i = t; stat_wr_i = w;
    mode_wr_i = mw; mode_wdata_i = md;
    m_max  = f_next_max(m_max, m_cnt, s, a, w);
    m_cnt  = f_next_cnt(m_cnt, s, t);
    if (s) m_hist = {m_hist[2:0], a};
    if (mw) m_mode = md;
    @(posedge clk);
    @(negedge clk);
    if (do_chk) begin
      chk(req, status_o, {12'd0, m_hist, m_max});
      chk(req, {30'd0, mode_o}, {30'd0, m_mode});
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step("R3", 0, 0, 1, 0, 0, 0, 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = 0; m_max = 0; m_hist = 0; m_mode = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R8", status_o, 32'd0);
    chk("R7", {30'd0, mode_o}, 32'd3);

    // R3/R4: 10 ticks, unhealthy start leaves max at zero
    ticks(10);
    step("R4", 1, 0, 0, 0, 0, 0, 1'b1);
    chk("R4", {16'd0, status_o[15:0]}, 32'd0);
    chk("R1", {28'd0, status_o[19:16]}, 32'd0);
    // R3: 7 ticks, healthy start records 7
    ticks(7);
    step("R4", 1, 1, 0, 0, 0, 0, 1'b1);
    chk("R4", {16'd0, status_o[15:0]}, 32'd7);
    chk("R1", {28'd0, status_o[19:16]}, 32'd1);
    // R4: shorter healthy interval does not lower the max
    ticks(3);
    step("R4", 1, 1, 0, 0, 0, 0, 1'b1);
    chk("R4", {16'd0, status_o[15:0]}, 32'd7);
    // R2: no start, history holds
    step("R2", 0, 1, 0, 0, 0, 0, 1'b1);
    chk("R2", {28'd0, status_o[19:16]}, 32'd3);
    // R3: tick in the start cycle is not counted; 9 ticks then a tick+start
    ticks(9);
    step("R3", 1, 1, 1, 0, 0, 0, 1'b1);
    chk("R3", {16'd0, status_o[15:0]}, 32'd9);
    // R5: clear wins over a qualifying update
    ticks(20);
    step("R5", 1, 1, 0, 1, 0, 0, 1'b1);
    chk("R5", {16'd0, status_o[15:0]}, 32'd0);
    // R1: history shifts out old samples
    step("R1", 1, 0, 0, 0, 0, 0, 1'b1);
    step("R1", 1, 1, 0, 0, 0, 0, 1'b1);
    chk("R1", {28'd0, status_o[19:16]}, 32'hD);
    // R7: every mode encoding
    for (int k = 0; k < 4; k++) begin
      step("R7", 0, 0, 0, 0, 1, 2'(k), 1'b1);
      chk("R7", {30'd0, mode_o}, 32'(k));
    end
    // R6: saturation past 65535 ticks
    step("R6", 1, 0, 0, 0, 0, 0, 1'b0);
    ticks(66000);
    step("R6", 1, 1, 0, 0, 0, 0, 1'b1);
    chk("R6", {16'd0, status_o[15:0]}, 32'd65535);
    step("R5", 0, 0, 0, 1, 0, 0, 1'b1);
    chk("R5", {16'd0, status_o[15:0]}, 32'd0);

    // constrained random mix, R1..R8
    for (int n = 0; n < 4000; n++) begin
      logic s, a, t, w, mw;
      logic [1:0] md;
      s  = ($urandom % 8) == 0;
      a  = ($urandom % 4) != 0;
      t  = ($urandom % 2) == 0;
      w  = ($urandom % 40) == 0;
      mw = ($urandom % 16) == 0;
      md = 2'($urandom);
      step("R4", s, a, t, w, mw, md, 1'b1);
    end
    chk("R8", {20'd0, status_o[31:20]}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule